// File: doc/BRIEF.md
# Serial Slow-Control Register Interface

This block is a synchronous four-wire serial slave for configuring and querying a multi-channel readout chip. The wires are an enable, a serial clock, a data input and a data output. A host opens a frame by raising the enable. It then sends a one-bit direction flag and a 7-bit register address, followed by a 72-bit data field. A write frame loads the data into the addressed register. A read frame returns the addressed register on the data output, after one turnaround clock.

The register file contains four general configuration words, a 72-bit channel-select mask and a read-only view of the 72-bit hit vector. The hit vector is produced elsewhere. The block only reads it back.

Input bits are taken on the rising edge of the serial clock. Output bits change on the falling edge, so each output bit is stable for half a period before the host samples it.

The frame controller uses the states IDLE, HEADER, TURN, RDATA, WDATA and DONE. It moves between them as follows:
- **IDLE to HEADER:** the enable is high at a rising edge, and the direction flag is captured on that edge.
- **HEADER to WDATA or TURN:** the seventh address bit has arrived. A write goes to WDATA and a read goes to TURN.
- **TURN to RDATA:** unconditional, on the next edge.
- **RDATA or WDATA to DONE:** the 72nd data bit has passed.
- **Any state to IDLE:** the enable is low at a rising edge.

Top module: `sc_serial_slave`

## Requirements
- R1: While rst_n is low, the four configuration words and chan_sel are zero and sc_dout is low.
- R2: A write frame sends a direction bit of 0 on rising edge 0, where edge 0 is the first edge with sc_en high. Address bits 6..0 follow MSB first on edges 1..7, and data bits 71..0 follow MSB first on edges 8..79. Addresses 0 to 3 select configuration words 0 to 3, which appear on cfg_q[i*72 +: 72].
- R3: A read frame sends a direction bit of 1. Bit 71 of the addressed register appears on sc_dout after the falling edge that follows rising edge 8. Each later bit appears one clock later, so the host samples bits 71..0 on rising edges 9..80.
- R4: Address 0x10 holds the channel-select mask. It can be written and read back, and it drives chan_sel.
- R5: A read of address 0x11 returns hit_in as sampled on rising edge 8. A write to address 0x11 changes no register.
- R6: A read of any other address returns all zeros, and a write to one changes no register.
- R7: If sc_en is low at any rising edge before the last data bit of a write, the frame is aborted and no register changes. The next frame decodes normally.
- R8: sc_dout is low at every time outside the read data phase: idle, header, read turnaround, the whole of a write frame, and after a frame.
- R9: A write changes only the register it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sc_clk | input | 1 | Serial clock; inputs are taken on the rising edge and the output changes on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sc_en | input | 1 | Frame enable, active high |
| sc_din | input | 1 | Serial data from the host |
| sc_dout | output | 1 | Serial data to the host |
| hit_in | input | 72 | Hit vector, readable at 0x11 |
| chan_sel | output | 72 | Channel-select mask |
| cfg_q | output | 288 | Four configuration words, with word i at bits i*72 +: 72 |

## Verification
A wrong frame state or a miscounted bit shows up within one frame in one of two ways:
- **Data shifted by one position:** a read returns data displaced by a bit.
- **Write to the wrong place:** a write lands in a neighbouring register, visible at once on cfg_q or chan_sel.

A stale controller state after an abort appears on the very next frame as a wrong readback. Every write is therefore followed by a read of the same address and by a comparison of every register port against a model. Output leakage is caught on the first clock that sc_dout is high outside the read data phase.

// File: rtl/sc_pkg.sv
package sc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEADER,
        ST_TURN,
        ST_RDATA,
        ST_WDATA,
        ST_DONE
    } sc_state_e;
endpackage

// File: rtl/sc_frame_ctrl.sv
module sc_frame_ctrl
    import sc_pkg::*;
#(
    parameter int DATA_W = 72,
    parameter int ADDR_W = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic din,
    output logic addr_shift_o,
    output logic wdata_shift_o,
    output logic rd_load_o,
    output logic rd_shift_o,
    output logic rd_drive_o,
    output logic commit_o
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    sc_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             rw_q;
    logic             hdr_last, data_last;

    assign hdr_last  = (cnt_q == CNT_W'(ADDR_W - 1));
    assign data_last = (cnt_q == CNT_W'(DATA_W - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (en) state_d = ST_HEADER;
            ST_HEADER: if (hdr_last) state_d = rw_q ? ST_TURN : ST_WDATA;
            ST_TURN:   state_d = ST_RDATA;
            ST_RDATA:  if (data_last) state_d = ST_DONE;
            ST_WDATA:  if (data_last) state_d = ST_DONE;
            ST_DONE:   state_d = ST_DONE;
            default:   state_d = ST_IDLE;
        endcase
        if (!en) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // bit counter restarts on every state change
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_d != state_q) begin
            cnt_q <= '0;
        end else if (state_q == ST_HEADER || state_q == ST_RDATA || state_q == ST_WDATA) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // direction flag captured on the opening edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        rw_q <= 1'b0;
        else if (state_q == ST_IDLE && en) rw_q <= din;
    end

    // outputs
    always_comb begin
        addr_shift_o  = (state_q == ST_HEADER) && en;
        wdata_shift_o = (state_q == ST_WDATA) && en;
        rd_load_o     = (state_q == ST_TURN) && en;
        rd_shift_o    = (state_q == ST_RDATA) && en;
        rd_drive_o    = (state_q == ST_RDATA);
        commit_o      = (state_q == ST_WDATA) && data_last && en;
    end
endmodule

// File: rtl/sc_shift_path.sv
module sc_shift_path #(
    parameter int DATA_W = 72,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din,
    input  logic              addr_shift,
    input  logic              wdata_shift,
    input  logic              rd_load,
    input  logic              rd_shift,
    input  logic              rd_drive,
    input  logic [DATA_W-1:0] rd_value,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_next,
    output logic              dout
);
    logic [DATA_W-1:0] wsh_q;
    logic [DATA_W-1:0] rsh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          addr_q <= '0;
        else if (addr_shift) addr_q <= {addr_q[ADDR_W-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           wsh_q <= '0;
        else if (wdata_shift) wsh_q <= wdata_next;
    end

    assign wdata_next = {wsh_q[DATA_W-2:0], din};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rsh_q <= '0;
        else if (rd_load)  rsh_q <= rd_value;
        else if (rd_shift) rsh_q <= {rsh_q[DATA_W-2:0], 1'b0};
    end

    // output launched on the falling edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) dout <= 1'b0;
        else        dout <= rd_drive ? rsh_q[DATA_W-1] : 1'b0;
    end
endmodule

// File: rtl/sc_reg_bank.sv
module sc_reg_bank #(
    parameter int DATA_W   = 72,
    parameter int ADDR_W   = 7,
    parameter int NUM_CFG  = 4,
    parameter int SEL_ADDR = 16,
    parameter int HIT_ADDR = 17
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [DATA_W-1:0]         hit_in,
    output logic [DATA_W-1:0]         rd_data,
    output logic [DATA_W-1:0]         chan_sel,
    output logic [NUM_CFG*DATA_W-1:0] cfg_flat
);
    logic [DATA_W-1:0] cfg_r [NUM_CFG];

    for (genvar gi = 0; gi < NUM_CFG; gi++) begin : g_cfg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                cfg_r[gi] <= '0;
            else if (wr_en && addr == ADDR_W'(gi))     cfg_r[gi] <= wr_data;
        end
        assign cfg_flat[gi*DATA_W +: DATA_W] = cfg_r[gi];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  chan_sel <= '0;
        else if (wr_en && addr == ADDR_W'(SEL_ADDR)) chan_sel <= wr_data;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CFG; i++) begin
            if (addr == ADDR_W'(i)) rd_data = cfg_r[i];
        end
        if (addr == ADDR_W'(SEL_ADDR)) rd_data = chan_sel;
        if (addr == ADDR_W'(HIT_ADDR)) rd_data = hit_in;
    end
endmodule

// File: rtl/sc_serial_slave.sv
module sc_serial_slave #(
    parameter int DATA_W   = 72,
    parameter int ADDR_W   = 7,
    parameter int NUM_CFG  = 4,
    parameter int SEL_ADDR = 16,
    parameter int HIT_ADDR = 17
) (
    input  logic                      sc_clk,
    input  logic                      rst_n,
    input  logic                      sc_en,
    input  logic                      sc_din,
    output logic                      sc_dout,
    input  logic [DATA_W-1:0]         hit_in,
    output logic [DATA_W-1:0]         chan_sel,
    output logic [NUM_CFG*DATA_W-1:0] cfg_q
);
    logic              addr_shift, wdata_shift, rd_load, rd_shift, rd_drive, wr_commit;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wr_data, rd_value;

    sc_frame_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk           (sc_clk),
        .rst_n         (rst_n),
        .en            (sc_en),
        .din           (sc_din),
        .addr_shift_o  (addr_shift),
        .wdata_shift_o (wdata_shift),
        .rd_load_o     (rd_load),
        .rd_shift_o    (rd_shift),
        .rd_drive_o    (rd_drive),
        .commit_o      (wr_commit)
    );

    sc_shift_path #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_shift (
        .clk         (sc_clk),
        .rst_n       (rst_n),
        .din         (sc_din),
        .addr_shift  (addr_shift),
        .wdata_shift (wdata_shift),
        .rd_load     (rd_load),
        .rd_shift    (rd_shift),
        .rd_drive    (rd_drive),
        .rd_value    (rd_value),
        .addr_q      (addr_q),
        .wdata_next  (wr_data),
        .dout        (sc_dout)
    );

    sc_reg_bank #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_CFG(NUM_CFG),
        .SEL_ADDR(SEL_ADDR), .HIT_ADDR(HIT_ADDR)
    ) u_bank (
        .clk      (sc_clk),
        .rst_n    (rst_n),
        .wr_en    (wr_commit),
        .addr     (addr_q),
        .wr_data  (wr_data),
        .hit_in   (hit_in),
        .rd_data  (rd_value),
        .chan_sel (chan_sel),
        .cfg_flat (cfg_q)
    );
endmodule

// File: rtl/sc_serial_slave_chk.sv
module sc_serial_slave_chk #(
    parameter int DATA_W   = 72,
    parameter int ADDR_W   = 7,
    parameter int NUM_CFG  = 4,
    parameter int SEL_ADDR = 16,
    parameter int HIT_ADDR = 17
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      en,
    input logic                      dout,
    input logic                      commit,
    input logic [ADDR_W-1:0]         addr,
    input logic [DATA_W-1:0]         wdata,
    input logic [DATA_W-1:0]         chan_sel,
    input logic [NUM_CFG*DATA_W-1:0] cfg
);
    // R8: an idle enable on the previous edge leaves the line low
    a_r8_dout_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> !dout);

    // R7: a register update only ever happens inside an enabled frame
    a_r7_commit_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> en);

    // R9: without an update strobe the mask holds
    a_r9_sel_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(chan_sel));

    // R9: without an update strobe the configuration words hold
    a_r9_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(cfg));

    // R4: a mask write lands on the chan_sel port
    a_r4_sel_written: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && addr == ADDR_W'(SEL_ADDR)) |=> chan_sel == $past(wdata));

    // R5: a write to the hit view changes nothing
    a_r5_hit_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && addr == ADDR_W'(HIT_ADDR)) |=> ($stable(chan_sel) && $stable(cfg)));
endmodule

bind sc_serial_slave sc_serial_slave_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_CFG(NUM_CFG),
    .SEL_ADDR(SEL_ADDR), .HIT_ADDR(HIT_ADDR)
) u_chk (
    .clk      (sc_clk),
    .rst_n    (rst_n),
    .en       (sc_en),
    .dout     (sc_dout),
    .commit   (wr_commit),
    .addr     (addr_q),
    .wdata    (wr_data),
    .chan_sel (chan_sel),
    .cfg      (cfg_q)
);

// File: tb/sc_serial_slave_bench.sv
module sc_serial_slave_bench;
    localparam int DW = 72;
    localparam int NV = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          din = 1'b0;
    logic          dout;
    logic [DW-1:0] hit = '0;
    logic [DW-1:0] sel;
    logic [4*DW-1:0] cfgq;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    bit in_write = 0;
    bit wr_noise = 0;

    logic [DW-1:0] cfg_m [4];
    logic [DW-1:0] sel_m;

    localparam logic [6:0] VA [NV] = '{7'h00, 7'h01, 7'h03, 7'h10, 7'h11, 7'h55, 7'h02, 7'h00};
    localparam logic [DW-1:0] VD [NV] = '{
        72'hA5_0123_4567_89AB_CDEF, 72'h80_0000_0000_0000_0001,
        72'hFF_FFFF_FFFF_FFFF_FFFF, 72'h3C_F0F0_0F0F_AAAA_5555,
        72'h12_3456_789A_BCDE_F012, 72'h77_7777_7777_7777_7777,
        72'h01_8000_0000_0000_0000, 72'h5A_5A5A_5A5A_5A5A_5A5A};

    sc_serial_slave u_sc_serial_slave (
        .sc_clk (clk), .rst_n (rst_n), .sc_en (en), .sc_din (din),
        .sc_dout (dout), .hit_in (hit), .chan_sel (sel), .cfg_q (cfgq));

    always #5 clk = ~clk;

    always @(posedge clk) begin
        #1;
        if (in_write && dout) wr_noise = 1;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 100000)", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_ports(input string req);
        for (int i = 0; i < 4; i++) check(req, cfgq[i*DW +: DW], cfg_m[i]);
        check(req, sel, sel_m);
    endtask

    function automatic logic [DW-1:0] expect_rd(input logic [6:0] a);
        if (a < 7'd4)   return cfg_m[a[1:0]];
        if (a == 7'h10) return sel_m;
        if (a == 7'h11) return hit;
        return '0;
    endfunction

    function automatic void model_write(input logic [6:0] a, input logic [DW-1:0] d);
        if (a < 7'd4)        cfg_m[a[1:0]] = d;
        else if (a == 7'h10) sel_m = d;
    endfunction

    // nbits: bits driven before the enable drops; 80 is a whole frame
    task automatic sc_write(input logic [6:0] a, input logic [DW-1:0] d, input int nbits);
        in_write = 1; wr_noise = 0;
        for (int k = 0; k < 80; k++) begin
            if (k >= nbits) break;
            @(negedge clk);
            en = 1;
            din = (k == 0) ? 1'b0 : (k < 8) ? a[7-k] : d[79-k];
        end
        @(negedge clk); en = 0; din = 0;
        @(negedge clk);
        in_write = 0;
    endtask

    task automatic sc_read(input logic [6:0] a, output logic [DW-1:0] d, output logic turn_bit);
        @(negedge clk); en = 1; din = 1;
        for (int k = 1; k < 8; k++) begin
            @(negedge clk); din = a[7-k];
        end
        @(negedge clk); din = 0;
        @(posedge clk); #1 turn_bit = dout;
        for (int j = 0; j < DW; j++) begin
            @(posedge clk); #1 d[DW-1-j] = dout;
        end
        @(negedge clk); en = 0;
        @(negedge clk);
    endtask

    function automatic string tag_for(input logic [6:0] a);
        if (a < 7'd4)   return "R2/R3";
        if (a == 7'h10) return "R4";
        if (a == 7'h11) return "R5";
        return "R6";
    endfunction

    initial begin
        logic [DW-1:0] rd;
        logic tb;
        for (int i = 0; i < 4; i++) cfg_m[i] = '0;
        sel_m = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 cfg", cfgq[DW-1:0], '0);
        check_ports("R1");
        check("R1 dout", {71'b0, dout}, '0);
        rst_n = 1;
        @(negedge clk);

        hit = 72'hC3_1111_2222_3333_4444;
        for (int v = 0; v < NV; v++) begin
            sc_write(VA[v], VD[v], 80);
            model_write(VA[v], VD[v]);
            check("R8 write quiet", {71'b0, wr_noise}, '0);
            check_ports("R9 ports");
            sc_read(VA[v], rd, tb);
            check(tag_for(VA[v]), rd, expect_rd(VA[v]));
            check("R8 turnaround", {71'b0, tb}, '0);
        end

        // R5: hit view follows hit_in
        hit = 72'h0F_EDCB_A987_6543_2100;
        sc_read(7'h11, rd, tb);
        check("R5 hit read", rd, 72'h0F_EDCB_A987_6543_2100);

        // R6: unmapped read
        sc_read(7'h7F, rd, tb);
        check("R6 unmapped", rd, '0);

        // R7: abort mid-data and mid-header
        sc_write(7'h01, 72'hDE_AD00_BEEF_0000_1234, 50);
        check_ports("R7 abort data");
        sc_write(7'h02, 72'hFF_0000_0000_0000_00FF, 4);
        check_ports("R7 abort header");
        sc_write(7'h01, 72'hDE_AD00_BEEF_0000_1234, 79);
        check_ports("R7 abort last bit");
        sc_read(7'h01, rd, tb);
        check("R7 recover", rd, cfg_m[1]);

        // R8: idle line
        @(posedge clk); #1 check("R8 idle", {71'b0, dout}, '0);

        // R1: reset in service
        @(negedge clk); rst_n = 0;
        @(negedge clk);
        for (int i = 0; i < 4; i++) cfg_m[i] = '0;
        sel_m = '0;
        check_ports("R1 rereset");
        rst_n = 1;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule